// File: doc/BRIEF.md
# Crosstalk-Avoiding Bus Line Receiver

This block terminates a wide on-chip bus that carries one 128-bit line as four 32-bit lanes, each lane followed by a separator field. The sender may hold a lane back for one or more cycles and drive an idle (NOP) segment on it instead, so that no wire ever switches against both of its neighbours. As a result, the four parts of a line can reach the receiver in different cycles. The receiver reads each lane's separator to tell a real segment from an idle one and latches every real segment into its own slot of the line. It presents the rebuilt line to the prefetch queue once all four slots are filled.

The line leaves through a valid/ready handshake. It holds steady until it is taken, and the filled-slot marks clear on the taking edge. A lane whose slot is still full that delivers a second real segment before the line has been taken breaks the protocol. The receiver drops that segment and raises a sticky error flag.

Top module: `xtalk_bus_rx`

## Requirements
- R1: Lane 1 data is read from bus wires [134:103], lane 2 from [100:69], lane 3 from [66:35] and lane 4 from [32:1].
- R2: Lanes 1 to 3 use the separator wire pairs {102,101}, {68,67} and {34,33}, upper wire first. Each of these lanes carries a real segment only when its pair reads 1,0, and every other pair value (0,0, 0,1, 1,1) is idle. Lane 4 uses wire 0 alone: 1 means real and 0 means idle.
- R3: The output line places lane 1 at [127:96], lane 2 at [95:64], lane 3 at [63:32] and lane 4 at [31:0].
- R4: An idle segment never changes a slot's contents and never marks a slot as filled, whatever its data wires carry.
- R5: Segments of one line may arrive in any cycles and in any lane order. `line_valid_o` rises on the clock edge that captures the last missing segment, and stays low while any slot is empty.
- R6: While `line_valid_o` is high and `line_ready_i` is low, the line and its valid stay unchanged.
- R7: A handshake (valid and ready both high at an edge) clears all filled marks on that edge. A real segment presented in that same cycle is captured as the first part of the next line.
- R8: A real segment on a lane whose slot is filled, in a cycle with no handshake, is dropped and sets `proto_err_o`. The flag then stays high until reset.
- R9: After reset, `line_valid_o` and `proto_err_o` are low.
- R10: When paired with a sender that gates lanes to avoid crosstalk, every line comes out unchanged and in sending order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_i | input | 135 | Bus wires: lane data and separator fields |
| line_o | output | 128 | Rebuilt line |
| line_valid_o | output | 1 | All four slots are filled |
| line_ready_i | input | 1 | Prefetch queue accepts the line |
| proto_err_o | output | 1 | Sticky flag for a duplicate segment |

## Verification
On every cycle, the in-RTL properties check four things:
- an idle segment leaves its slot and its filled mark alone;
- a handshake clears a slot's mark;
- a duplicate segment leaves its slot untouched and raises the sticky error;
- a stalled line stays frozen.

Only the bench's scenarios can show the rest:
- the exact wire-to-lane and lane-to-line mapping;
- the rejection of the odd separator codes;
- capture of a segment in the same cycle as the handshake.

The paired-sender stream, with lanes arriving out of step and a ready that varies, is what shows that lines arrive whole and in order while the bus never carries a 3C or 4C transition.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

   // Separator pair code for lanes that carry two separator wires
   typedef enum logic [1:0] {
      SEP_IDLE = 2'b00,
      SEP_LOW  = 2'b01,
      SEP_REAL = 2'b10,
      SEP_BOTH = 2'b11
   } sep_code_e;

   // Lowest data wire of lane k; lane 0 sits at the top of the bus
   function automatic int unsigned lane_data_lsb(input int unsigned lanes,
                                                 input int unsigned seg_w,
                                                 input int unsigned k);
      return (lanes - 1 - k) * (seg_w + 2) + 1;
   endfunction

   // Lowest bit of lane k inside the output line
   function automatic int unsigned lane_line_lsb(input int unsigned lanes,
                                                 input int unsigned seg_w,
                                                 input int unsigned k);
      return (lanes - 1 - k) * seg_w;
   endfunction

endpackage

// File: rtl/xbr_lane_tap.sv
module xbr_lane_tap #(
   parameter int unsigned SEG_W = 32,
   parameter int unsigned SEP_W = 2
) (
   input  logic [SEG_W+SEP_W-1:0] wires_i,
   output logic [SEG_W-1:0]       seg_o,
   output logic                   real_o
);
   import xbr_pkg::*;

   assign seg_o = wires_i[SEG_W+SEP_W-1 -: SEG_W];

   generate
      if (SEP_W == 2) begin : g_pair
         sep_code_e code;
         assign code   = sep_code_e'(wires_i[1:0]);
         assign real_o = (code == SEP_REAL);
      end else if (SEP_W == 1) begin : g_single
         assign real_o = wires_i[0];
      end else begin : g_bad
         $error("xbr_lane_tap: SEP_W must be 1 or 2");
      end
   endgenerate

endmodule

// File: rtl/xbr_slot.sv
module xbr_slot #(
   parameter int unsigned SEG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEG_W-1:0] seg_i,
   input  logic             real_i,
   input  logic             pop_i,
   output logic [SEG_W-1:0] slot_o,
   output logic             rcvd_o,
   output logic             dup_o
);
   logic [SEG_W-1:0] slot_q;
   logic             rcvd_q;
   logic             take;

   assign take  = real_i & (~rcvd_q | pop_i);
   assign dup_o = real_i & rcvd_q & ~pop_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         rcvd_q <= 1'b0;
      end else if (take) begin
         slot_q <= seg_i;
         rcvd_q <= 1'b1;
      end else if (pop_i) begin
         rcvd_q <= 1'b0;
      end
   end

   assign slot_o = slot_q;
   assign rcvd_o = rcvd_q;

   AST_IDLE_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !real_i |=> $stable(slot_o)); // R4
   AST_IDLE_NO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (!real_i && !rcvd_o) |=> !rcvd_o); // R4
   AST_POP_CLEARS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !real_i) |=> !rcvd_o); // R7
   AST_DUP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      dup_o |=> $stable(slot_o)); // R8

endmodule

// File: rtl/xtalk_bus_rx.sv
module xtalk_bus_rx #(
   parameter int unsigned LANES = 4,
   parameter int unsigned SEG_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [LANES*(SEG_W+2)-2:0]   bus_i,
   output logic [LANES*SEG_W-1:0]       line_o,
   output logic                         line_valid_o,
   input  logic                         line_ready_i,
   output logic                         proto_err_o
);
   import xbr_pkg::*;

   localparam int unsigned BUS_W  = LANES * (SEG_W + 2) - 1;
   localparam int unsigned LINE_W = LANES * SEG_W;

   generate
      if (LANES < 1) begin : g_chk_lanes
         $error("xtalk_bus_rx: LANES must be at least 1");
      end
      if (SEG_W < 2) begin : g_chk_seg
         $error("xtalk_bus_rx: SEG_W must be at least 2");
      end
      if (BUS_W != $bits(bus_i) || LINE_W != $bits(line_o)) begin : g_chk_w
         $error("xtalk_bus_rx: derived widths do not match ports");
      end
   endgenerate

   logic [LANES-1:0][SEG_W-1:0] seg;
   logic [LANES-1:0][SEG_W-1:0] slot_q;
   logic [LANES-1:0]            seg_real;
   logic [LANES-1:0]            rcvd;
   logic [LANES-1:0]            dup;
   logic                        pop;
   logic                        err_q;

   assign line_valid_o = &rcvd;
   assign pop          = line_valid_o & line_ready_i;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int unsigned DL   = lane_data_lsb(LANES, SEG_W, k);
      localparam int unsigned LL   = lane_line_lsb(LANES, SEG_W, k);
      localparam int unsigned SEPW = (k == LANES - 1) ? 1 : 2;

      xbr_lane_tap #(.SEG_W(SEG_W), .SEP_W(SEPW)) u_tap (
         .wires_i (bus_i[DL+SEG_W-1 : DL-SEPW]),
         .seg_o   (seg[k]),
         .real_o  (seg_real[k])
      );

      xbr_slot #(.SEG_W(SEG_W)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .seg_i  (seg[k]),
         .real_i (seg_real[k]),
         .pop_i  (pop),
         .slot_o (slot_q[k]),
         .rcvd_o (rcvd[k]),
         .dup_o  (dup[k])
      );

      assign line_o[LL +: SEG_W] = slot_q[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    err_q <= 1'b0;
      else if (|dup) err_q <= 1'b1;
   end

   assign proto_err_o = err_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_o |=> proto_err_o); // R8
   AST_DUP_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (|dup) |=> proto_err_o); // R8
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (line_valid_o && !line_ready_i) |=> (line_valid_o && $stable(line_o))); // R6

endmodule

// File: tb/xtalk_bus_rx_test.sv
`timescale 1ns/1ps
module xtalk_bus_rx_test;
   localparam int L  = 4;
   localparam int S  = 32;
   localparam int BW = L * (S + 2) - 1;
   localparam int LW = L * S;
   localparam int NL = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [BW-1:0] bus = '0;
   logic          rdy = 1'b0;
   logic [LW-1:0] line_o;
   logic          line_valid_o;
   logic          proto_err_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   xtalk_bus_rx #(.LANES(L), .SEG_W(S)) uut (
      .clk(clk), .rst_n(rst_n), .bus_i(bus), .line_o(line_o),
      .line_valid_o(line_valid_o), .line_ready_i(rdy), .proto_err_o(proto_err_o)
   );

   function automatic int dlsb(int k);
      return (L - 1 - k) * (S + 2) + 1;
   endfunction

   task automatic check(bit ok, string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_seg(int k, logic [S-1:0] d, logic [1:0] sep);
      bus[dlsb(k) +: S] = d;
      bus[dlsb(k) - 1]  = sep[1];
      if (k < L - 1) bus[dlsb(k) - 2] = sep[0];
   endtask

   function automatic bit is_real(logic [BW-1:0] b, int k);
      if (k == L - 1) return b[dlsb(k) - 1];
      return b[dlsb(k) - 1] && !b[dlsb(k) - 2];
   endfunction

   function automatic logic [LW-1:0] line_of(int i);
      logic [LW-1:0] v;
      for (int k = 0; k < L; k++) begin
         logic [S-1:0] s;
         case (i % 4)
            0: s = (k % 2 == 0) ? 32'h5555_5555 : 32'hAAAA_AAAA;
            1: s = (i + 1) * 32'h9E37_79B9 ^ (k * 32'h0101_0101);
            2: s = ((i + k) % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_0000;
            default: s = {8{4'(i + k)}};
         endcase
         v[(L - 1 - k) * S +: S] = s;
      end
      return v;
   endfunction

   function automatic bit has_xt(logic [BW-1:0] a, logic [BW-1:0] b);
      for (int i = 1; i < BW - 1; i++) begin
         int d, dl, dr, opp, st;
         d  = int'(b[i]) - int'(a[i]);
         dl = int'(b[i-1]) - int'(a[i-1]);
         dr = int'(b[i+1]) - int'(a[i+1]);
         if (d != 0) begin
            opp = (dl == -d ? 1 : 0) + (dr == -d ? 1 : 0);
            st  = (dl == 0 ? 1 : 0) + (dr == 0 ? 1 : 0);
            if (opp == 2 || (opp == 1 && st == 1)) return 1'b1;
         end
      end
      return 1'b0;
   endfunction

   // behavioural reference model, updated on every edge
   logic [S-1:0]  m_slot [L];
   bit            m_rcvd [L];
   bit            m_err;
   bit            stream = 0;
   int            popped = 0;
   logic [BW-1:0] bus_prev = '0;

   function automatic logic [LW-1:0] m_line();
      logic [LW-1:0] v;
      for (int k = 0; k < L; k++) v[(L - 1 - k) * S +: S] = m_slot[k];
      return v;
   endfunction

   function automatic bit m_valid();
      for (int k = 0; k < L; k++) if (!m_rcvd[k]) return 1'b0;
      return 1'b1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < L; k++) begin m_slot[k] = '0; m_rcvd[k] = 0; end
         m_err = 0;
      end else begin
         bit pop;
         pop = m_valid() && rdy;
         if (stream && line_valid_o && rdy) begin
            check(line_o == line_of(popped), "R10 line content/order", line_o, line_of(popped));
            popped++;
         end
         if (stream) begin
            check(!has_xt(bus_prev, bus), "R10 no 3C/4C on bus", LW'(bus), LW'(bus_prev));
         end
         bus_prev = bus;
         for (int k = 0; k < L; k++) begin
            if (is_real(bus, k)) begin
               if (!m_rcvd[k] || pop) begin
                  m_slot[k] = bus[dlsb(k) +: S];
                  m_rcvd[k] = 1;
               end else m_err = 1;
            end else if (pop) m_rcvd[k] = 0;
         end
      end
   end

   task automatic compare();
      check(line_valid_o == m_valid(), "R5 valid vs model", LW'(line_valid_o), LW'(m_valid()));
      if (m_valid()) check(line_o == m_line(), "R3 line vs model", line_o, m_line());
      check(proto_err_o == m_err, "R8 error vs model", LW'(proto_err_o), LW'(m_err));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [LW-1:0] la, lb, held;
      la = {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_1E1E, 32'hC001_D00D};
      lb = {32'hB0B0_0001, 32'hB0B0_0002, 32'hB0B0_0003, 32'hB0B0_0004};
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check(line_valid_o == 1'b0, "R9 valid after reset", LW'(line_valid_o), '0);
      check(proto_err_o == 1'b0, "R9 error after reset", LW'(proto_err_o), '0);

      // lanes 1 and 3 first; lane 2 shows 1,1 (idle, R2); lane 4 idle
      set_seg(0, la[127:96], 2'b10);
      set_seg(1, 32'hDEAD_0001, 2'b11);
      set_seg(2, la[63:32], 2'b10);
      set_seg(3, 32'hDEAD_0003, 2'b00);
      tick();
      check(line_valid_o == 1'b0, "R5 partial line not valid", LW'(line_valid_o), '0);

      // lanes 2 and 4 complete the line; lane 3 shows 0,1 which is idle (R2)
      set_seg(0, 32'hFFFF_0000, 2'b00);
      set_seg(1, la[95:64], 2'b10);
      set_seg(2, 32'h0BAD_0BAD, 2'b01);
      set_seg(3, la[31:0], 2'b10);
      tick();
      check(line_valid_o == 1'b1, "R5 valid after last lane", LW'(line_valid_o), LW'(1));
      check(line_o == la, "R1 R3 lane mapping", line_o, la);
      check(proto_err_o == 1'b0, "R2 odd separator codes are idle", LW'(proto_err_o), '0);

      // idle traffic with changing data under stall
      for (int c = 0; c < 3; c++) begin
         for (int k = 0; k < L; k++) set_seg(k, 32'hA5A5_0000 + c * 17 + k, 2'b00);
         tick();
      end
      check(line_o == la, "R4 idle segments leave line", line_o, la);
      check(line_valid_o == 1'b1, "R6 valid held under stall", LW'(line_valid_o), LW'(1));

      // duplicate real segment on lane 2 without handshake
      held = line_o;
      set_seg(1, 32'h1111_1111, 2'b10);
      tick();
      check(proto_err_o == 1'b1, "R8 duplicate raises error", LW'(proto_err_o), LW'(1));
      check(line_o == held, "R8 duplicate dropped", line_o, held);
      set_seg(1, 32'h1111_1111, 2'b00);
      tick();
      check(proto_err_o == 1'b1, "R8 error sticky", LW'(proto_err_o), LW'(1));

      // handshake with a real lane-4 segment in the same cycle
      rdy = 1'b1;
      set_seg(3, lb[31:0], 2'b10);
      tick();
      check(line_valid_o == 1'b0, "R7 handshake clears marks", LW'(line_valid_o), '0);
      rdy = 1'b0;
      set_seg(3, lb[31:0], 2'b00);
      set_seg(0, lb[127:96], 2'b10);
      set_seg(1, lb[95:64], 2'b10);
      set_seg(2, lb[63:32], 2'b10);
      tick();
      check(line_o == lb, "R7 pop-cycle segment kept", line_o, lb);
      check(line_valid_o == 1'b1, "R7 next line valid", LW'(line_valid_o), LW'(1));
      check(proto_err_o == 1'b1, "R8 error stays until reset", LW'(proto_err_o), LW'(1));

      // reset, then paired crosstalk-avoiding sender stream
      for (int k = 0; k < L; k++) set_seg(k, '0, 2'b00);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check(proto_err_o == 1'b0, "R9 reset clears error", LW'(proto_err_o), '0);
      bus = '0;
      @(posedge clk);
      @(negedge clk);
      stream = 1;
      begin
         int  idx [L];
         bit  sent [L];
         int  cyc;
         for (int k = 0; k < L; k++) begin idx[k] = 0; sent[k] = 0; end
         cyc = 0;
         while (popped < NL) begin
            logic [BW-1:0] nxt;
            compare();
            nxt = bus;
            for (int k = 0; k < L; k++) begin
               logic [S-1:0] cur, tgt, nb;
               logic [BW-1:0] cand;
               cur = bus[dlsb(k) +: S];
               if (sent[k]) begin
                  nxt[dlsb(k) - 1] = 1'b0;
                  sent[k] = 0;
                  idx[k]++;
               end else if (idx[k] < NL && popped == idx[k] && ((cyc + k) % 3 != 0)) begin
                  tgt = line_of(idx[k])[(L - 1 - k) * S +: S];
                  cand = nxt;
                  cand[dlsb(k) +: S] = tgt;
                  cand[dlsb(k) - 1] = 1'b1;
                  if (!has_xt(bus, cand)) begin
                     nxt = cand;
                     sent[k] = 1;
                  end else begin
                     nb = cur;
                     for (int j = 0; j < S; j += 2) nb[j] = tgt[j];
                     if (nb == cur) for (int j = 1; j < S; j += 2) nb[j] = tgt[j];
                     nxt[dlsb(k) +: S] = nb;
                  end
               end
            end
            bus = nxt;
            rdy = ((cyc % 7) != 3) && ((cyc % 5) != 1);
            cyc++;
            @(posedge clk);
            @(negedge clk);
         end
      end
      check(popped == NL, "R10 all lines delivered", LW'(popped), LW'(NL));
      check(proto_err_o == 1'b0, "R8 no error in clean stream", LW'(proto_err_o), '0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule